// File: doc/BRIEF.md
# Synchronous Serial Port Register and FIFO Front End

This block is the processor-facing half of a synchronous serial port master. It decodes a 4 KB window on a simple word-addressed bus, keeps the control, prescale and interrupt-mask registers, and holds two 8-entry queues of 16-bit words: one for words waiting to be sent and one for words that came back. A separate shift engine, outside this block, takes the oldest outgoing word and hands back one incoming word in the same handshake. The front end trims both words to the programmed frame size.

Status flags and interrupt sources are derived purely from the two queue fill levels. The outgoing-side source is raised while that queue is at most half full, and the incoming-side source while the incoming queue is at least half full. A single level interrupt output combines the sources with the mask. Reading the data register pops the incoming queue. Writing it pushes the outgoing queue. The shift engine is stalled whenever the incoming queue has no room, so no received word is ever lost.

Top module: `ssp_frontend`

## Requirements
- R1: Word offsets (byte offset / 4) decode as: 0 frame control (16 bits, read back as written), 1 run control (bit 1 = enable, the only stored bit), 2 data, 3 status, 4 prescale, 5 interrupt mask (bits 3:0), 6 raw sources, 7 masked sources, 8 DMA control.
- R2: Status reads {busy, rx_full, rx_not_empty, tx_not_full, tx_empty} in bits 4 down to 0. Busy is 1 whenever the outgoing queue holds at least one word.
- R3: The outgoing queue holds 8 words. A data write while it holds 8 words is dropped, and the queue keeps its contents.
- R4: A data read returns the oldest incoming word and removes it. A data read while the incoming queue is empty returns 0 and changes no state.
- R5: xfer_req is high exactly when enable is set, the outgoing queue is non-empty and the incoming queue is not full. xfer_word is then the oldest outgoing word. On a cycle with xfer_req and xfer_ack both high, that word is removed and xfer_rx, trimmed to the frame size, is appended to the incoming queue.
- R6: Frame size field N is frame control bits 3:0. Written words and returned words are both ANDed with 2^(N+1)-1 before they are stored.
- R7: Raw source bit 2 is 1 when the incoming queue holds 4 or more words. Raw source bit 3 is 1 when the outgoing queue holds 4 or fewer words. Raw bits 1:0 read 0.
- R8: irq is high when (mask AND raw) is non-zero. The masked register reads that AND.
- R9: The prescale register keeps only its low 8 bits. The DMA control register always reads 0.
- R10: After reset both queues are empty, the mask is 0, raw reads 0x8, status reads 0x03, and irq is low.
- R11: Word offsets 0x3F8 to 0x3FF form an identification region. Word offset 0x3F8+k reads ID_BASE+k (default ID_BASE 0xC0), and writes to it are ignored.
- R12: Undefined offsets read 0 and writes to them change nothing. Writes to the status, raw and masked registers change nothing, and reads of the raw and masked registers have no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address within the 4 KB window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the access cycle |
| irq | output | 1 | Level interrupt |
| xfer_req | output | 1 | Word available for the shift engine |
| xfer_word | output | 16 | Oldest outgoing word |
| xfer_ack | input | 1 | Engine takes xfer_word and supplies xfer_rx |
| xfer_rx | input | 16 | Word returned by the engine |

## Verification
A corrupted queue pointer or count appears at the ports either at once or on the next access. The status and raw registers and irq show it combinationally in the same cycle. A wrong read index shows up at the next data read as a word out of order, and at the engine handshake as an xfer_word that differs from the order in which the words were written. A stuck count shows up as a stall that never clears, or as a data write that is lost, and the following status read exposes it. The frame mask and the stall rule are observed where words cross the engine handshake, which catches a lost or duplicated word in the cycle it moves.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int WORD_W = 16;
    localparam int ADDR_W = 10;
    localparam int FRM_W  = $clog2(WORD_W);

    // word offsets inside the window
    localparam logic [ADDR_W-1:0] OFS_FRAME   = 10'h000;
    localparam logic [ADDR_W-1:0] OFS_RUN     = 10'h001;
    localparam logic [ADDR_W-1:0] OFS_DATA    = 10'h002;
    localparam logic [ADDR_W-1:0] OFS_STATUS  = 10'h003;
    localparam logic [ADDR_W-1:0] OFS_PRESC   = 10'h004;
    localparam logic [ADDR_W-1:0] OFS_MASK    = 10'h005;
    localparam logic [ADDR_W-1:0] OFS_RAW     = 10'h006;
    localparam logic [ADDR_W-1:0] OFS_MASKED  = 10'h007;
    localparam logic [ADDR_W-1:0] OFS_DMA     = 10'h008;
    localparam logic [ADDR_W-1:0] OFS_ID_BASE = 10'h3F8;

    // status word, bit 4 down to bit 0
    typedef struct packed {
        logic busy;
        logic rx_full;
        logic rx_nempty;
        logic tx_nfull;
        logic tx_empty;
    } stat_t;

    // interrupt sources, bit 3 down to bit 0
    typedef struct packed {
        logic tx_src;
        logic rx_src;
        logic tmo_src;
        logic ovr_src;
    } isrc_t;

    function automatic logic [WORD_W-1:0] frame_mask(input logic [FRM_W-1:0] n);
        logic [WORD_W:0] m;
        m = (WORD_W+1)'(1) << (32'(n) + 1);
        m = m - (WORD_W+1)'(1);
        return m[WORD_W-1:0];
    endfunction

endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CNT_W-1:0] count
);

    // DEPTH must be a power of two: the read index wraps by truncation
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wptr;
    logic [CNT_W-1:0] cnt;
    logic [PTR_W-1:0] rd_idx;

    assign rd_idx = wptr - cnt[PTR_W-1:0];
    assign dout   = mem[rd_idx];
    assign count  = cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            cnt  <= '0;
        end else begin
            if (push) wptr <= wptr + PTR_W'(1);
            cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= din;
    end

    // R3
    push_full_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> (cnt != CNT_W'(DEPTH) || pop));

    // R4
    pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> (cnt != '0));

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(DEPTH));

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (push || pop) |=> (cnt == $past(cnt) + CNT_W'($past(push)) - CNT_W'($past(pop))));

endmodule

// File: rtl/ssp_csr.sv
module ssp_csr
    import ssp_pkg::*;
#(
    parameter int         DEPTH   = 8,
    parameter logic [7:0] ID_BASE = 8'hC0,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [CNT_W-1:0]  tx_cnt,
    input  logic [CNT_W-1:0]  rx_cnt,
    input  logic [WORD_W-1:0] rx_head,
    output logic [WORD_W-1:0] rdata,
    output logic              enable,
    output logic [WORD_W-1:0] fmask,
    output logic              irq
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

    logic [WORD_W-1:0] frame_q;
    logic              run_q;
    logic [7:0]        presc_q;
    isrc_t             mask_q;
    stat_t             stat;
    isrc_t             raw;
    isrc_t             masked;
    logic              wr_en;

    assign wr_en = sel && wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
            run_q   <= 1'b0;
            presc_q <= '0;
            mask_q  <= '0;
        end else if (wr_en) begin
            case (addr)
                OFS_FRAME: frame_q <= wdata;
                OFS_RUN:   run_q   <= wdata[1];
                OFS_PRESC: presc_q <= wdata[7:0];
                OFS_MASK:  mask_q  <= isrc_t'(wdata[3:0]);
                default:   ;
            endcase
        end
    end

    always_comb begin
        stat.tx_empty  = (tx_cnt == '0);
        stat.tx_nfull  = (tx_cnt != FULL_CNT);
        stat.rx_nempty = (rx_cnt != '0);
        stat.rx_full   = (rx_cnt == FULL_CNT);
        stat.busy      = (tx_cnt != '0);
        raw.tx_src     = (tx_cnt <= HALF_CNT);
        raw.rx_src     = (rx_cnt >= HALF_CNT);
        raw.tmo_src    = 1'b0;
        raw.ovr_src    = 1'b0;
    end

    assign masked = mask_q & raw;
    assign irq    = |masked;
    assign enable = run_q;
    assign fmask  = frame_mask(frame_q[FRM_W-1:0]);

    always_comb begin
        rdata = '0;
        if (sel && !wr) begin
            if (addr >= OFS_ID_BASE) begin
                rdata = WORD_W'(8'(ID_BASE + {5'd0, addr[2:0]}));
            end else begin
                case (addr)
                    OFS_FRAME:  rdata = frame_q;
                    OFS_RUN:    rdata = WORD_W'({run_q, 1'b0});
                    OFS_DATA:   rdata = (rx_cnt != '0) ? rx_head : '0;
                    OFS_STATUS: rdata = WORD_W'(stat);
                    OFS_PRESC:  rdata = WORD_W'(presc_q);
                    OFS_MASK:   rdata = WORD_W'(mask_q);
                    OFS_RAW:    rdata = WORD_W'(raw);
                    OFS_MASKED: rdata = WORD_W'(masked);
                    default:    rdata = '0;
                endcase
            end
        end
    end

    // R8
    irq_nomask_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq);

    // R7
    src_half_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_cnt > HALF_CNT) |-> !raw.tx_src);

endmodule

// File: rtl/ssp_frontend.sv
module ssp_frontend
    import ssp_pkg::*;
#(
    parameter int         DEPTH   = 8,
    parameter logic [7:0] ID_BASE = 8'hC0,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq,
    output logic              xfer_req,
    output logic [WORD_W-1:0] xfer_word,
    input  logic              xfer_ack,
    input  logic [WORD_W-1:0] xfer_rx
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [CNT_W-1:0]  tx_cnt;
    logic [CNT_W-1:0]  rx_cnt;
    logic [WORD_W-1:0] tx_head;
    logic [WORD_W-1:0] rx_head;
    logic [WORD_W-1:0] fmask;
    logic              enable;
    logic              data_wr;
    logic              data_rd;
    logic              tx_push;
    logic              rx_pop;
    logic              xchg;

    assign data_wr = bus_sel &&  bus_wr && (bus_addr == OFS_DATA);
    assign data_rd = bus_sel && !bus_wr && (bus_addr == OFS_DATA);
    assign tx_push = data_wr && (tx_cnt != FULL_CNT);
    assign rx_pop  = data_rd && (rx_cnt != '0);

    // the engine runs only while there is a word to send and room for the reply
    assign xfer_req  = enable && (tx_cnt != '0) && (rx_cnt != FULL_CNT);
    assign xfer_word = tx_head;
    assign xchg      = xfer_req && xfer_ack;

    ssp_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .push  (tx_push),
        .din   (bus_wdata & fmask),
        .pop   (xchg),
        .dout  (tx_head),
        .count (tx_cnt)
    );

    ssp_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .push  (xchg),
        .din   (xfer_rx & fmask),
        .pop   (rx_pop),
        .dout  (rx_head),
        .count (rx_cnt)
    );

    ssp_csr #(.DEPTH(DEPTH), .ID_BASE(ID_BASE)) u_csr (
        .clk     (clk),
        .rst     (rst),
        .sel     (bus_sel),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .tx_cnt  (tx_cnt),
        .rx_cnt  (rx_cnt),
        .rx_head (rx_head),
        .rdata   (bus_rdata),
        .enable  (enable),
        .fmask   (fmask),
        .irq     (irq)
    );

    // R5
    exch_rx_chk: assert property (@(posedge clk) disable iff (rst)
        xchg |=> (rx_cnt == $past(rx_cnt) + CNT_W'(1) - CNT_W'($past(rx_pop))));

    // R3
    drop_full_chk: assert property (@(posedge clk) disable iff (rst)
        (data_wr && tx_cnt == FULL_CNT && !xchg) |=> (tx_cnt == FULL_CNT));

    // R4
    empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        (data_rd && rx_cnt == '0 && !xchg) |=> (rx_cnt == '0));

    // R10
    rst_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (tx_cnt == '0 && rx_cnt == '0 && !irq));

endmodule

// File: tb/tb_ssp_frontend.sv
module tb_ssp_frontend;
    import ssp_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [WORD_W-1:0] bus_wdata = '0;
    logic [WORD_W-1:0] bus_rdata;
    logic              irq;
    logic              xfer_req;
    logic [WORD_W-1:0] xfer_word;
    logic              xfer_ack;
    logic [WORD_W-1:0] xfer_rx;
    logic              eng_on = 1'b0;

    localparam logic [WORD_W-1:0] ENG_XOR = 16'h5A5A;

    int checks = 0;
    int errors = 0;

    // scoreboard model
    logic [WORD_W-1:0] txq[$];
    logic [WORD_W-1:0] rxq[$];
    logic [WORD_W-1:0] m_mask = 16'h0001;
    logic              m_en = 1'b0;

    always #5 clk = ~clk;

    // shift engine stand-in: answers in the same cycle
    assign xfer_ack = eng_on;
    assign xfer_rx  = xfer_word ^ ENG_XOR;

    ssp_frontend dut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .xfer_req  (xfer_req),
        .xfer_word (xfer_word),
        .xfer_ack  (xfer_ack),
        .xfer_rx   (xfer_rx)
    );

    task automatic check(input string tag, input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // driver: writes also feed the scoreboard
    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] d);
        @(posedge clk);
        #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        if (a == OFS_DATA && txq.size() < 8) txq.push_back(d & m_mask);
        if (a == OFS_FRAME) m_mask = frame_mask(d[FRM_W-1:0]);
        if (a == OFS_RUN) m_en = d[1];
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [WORD_W-1:0] d);
        @(posedge clk);
        #1;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2;
        d = bus_rdata;
        @(posedge clk);
        #1;
        bus_sel = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] exp);
        logic [WORD_W-1:0] d;
        bus_read(a, d);
        check(tag, d, exp);
    endtask

    // data read compared against the scoreboard's oldest received word
    task automatic data_chk(input string tag, output logic [WORD_W-1:0] got);
        logic [WORD_W-1:0] exp;
        @(posedge clk);
        #1;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = OFS_DATA;
        #2;
        got = bus_rdata;
        exp = (rxq.size() != 0) ? rxq.pop_front() : '0;
        check(tag, got, exp);
        @(posedge clk);
        #1;
        bus_sel = 1'b0;
    endtask

    task automatic irq_chk(input string tag, input logic exp);
        @(posedge clk);
        #3;
        check(tag, {15'd0, irq}, {15'd0, exp});
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    // monitor: each engine handshake pops the expected outgoing word
    initial begin
        logic [WORD_W-1:0] exp;
        forever begin
            @(posedge clk);
            #4;
            if (!rst && xfer_req) begin
                if (!m_en || rxq.size() == 8 || txq.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R5 unexpected xfer_req actual=1 expected=0");
                end else if (xfer_ack) begin
                    exp = txq.pop_front();
                    check("R5 xfer_word order", xfer_word, exp);
                    rxq.push_back((exp ^ ENG_XOR) & m_mask);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        logic [WORD_W-1:0] d;
        idle(3);
        #1 rst = 1'b0;

        // reset state
        rd_chk("R10 status", OFS_STATUS, 16'h0003);
        rd_chk("R10 raw", OFS_RAW, 16'h0008);
        rd_chk("R10 mask", OFS_MASK, 16'h0000);
        rd_chk("R10 masked", OFS_MASKED, 16'h0000);
        irq_chk("R10 irq", 1'b0);
        data_chk("R4 empty read at reset", d);

        // register map and readback
        bus_write(OFS_FRAME, 16'h0007);
        rd_chk("R1 frame readback", OFS_FRAME, 16'h0007);
        bus_write(OFS_RUN, 16'h0000);
        rd_chk("R1 run readback", OFS_RUN, 16'h0000);
        bus_write(OFS_PRESC, 16'h1234);
        rd_chk("R9 prescale low byte", OFS_PRESC, 16'h0034);
        bus_write(OFS_DMA, 16'hFFFF);
        rd_chk("R9 dma reads zero", OFS_DMA, 16'h0000);
        rd_chk("R12 undefined read", 10'h009, 16'h0000);
        bus_write(10'h009, 16'hFFFF);
        bus_write(OFS_STATUS, 16'hFFFF);
        bus_write(OFS_RAW, 16'hFFFF);
        bus_write(OFS_MASKED, 16'hFFFF);
        rd_chk("R12 frame after stray writes", OFS_FRAME, 16'h0007);
        rd_chk("R12 status after stray writes", OFS_STATUS, 16'h0003);
        rd_chk("R12 raw unchanged", OFS_RAW, 16'h0008);
        rd_chk("R12 raw read again", OFS_RAW, 16'h0008);

        // identification region
        for (int k = 0; k < 8; k++) begin
            rd_chk("R11 id byte", OFS_ID_BASE + ADDR_W'(k), 16'(8'hC0 + k));
        end
        bus_write(OFS_ID_BASE, 16'h0000);
        rd_chk("R11 id write ignored", OFS_ID_BASE, 16'h00C0);

        // interrupt masking with the outgoing source active
        bus_write(OFS_MASK, 16'h0008);
        irq_chk("R8 irq on tx source", 1'b1);
        rd_chk("R8 masked", OFS_MASKED, 16'h0008);
        bus_write(OFS_MASK, 16'h0004);
        irq_chk("R8 irq masked off", 1'b0);
        rd_chk("R8 masked zero", OFS_MASKED, 16'h0000);

        // fill the outgoing queue with the engine stopped
        for (int k = 0; k < 4; k++) bus_write(OFS_DATA, 16'hAB10 + 16'(k));
        rd_chk("R7 tx four entries raises source", OFS_RAW, 16'h0008);
        bus_write(OFS_DATA, 16'hAB14);
        rd_chk("R7 tx five entries clears source", OFS_RAW, 16'h0000);
        for (int k = 5; k < 8; k++) bus_write(OFS_DATA, 16'hAB10 + 16'(k));
        rd_chk("R2 tx full status", OFS_STATUS, 16'h0010);
        bus_write(OFS_DATA, 16'hEEEE);
        rd_chk("R3 drop when full", OFS_STATUS, 16'h0010);
        check("R5 no request while disabled", {15'd0, xfer_req}, 16'h0000);

        // run the engine
        eng_on = 1'b1;
        bus_write(OFS_RUN, 16'h0002);
        idle(12);
        rd_chk("R2 rx full after exchange", OFS_STATUS, 16'h000F);
        rd_chk("R7 both sources", OFS_RAW, 16'h000C);
        irq_chk("R8 irq on rx source", 1'b1);

        // stall while the incoming queue is full
        bus_write(OFS_DATA, 16'h0061);
        bus_write(OFS_DATA, 16'h0062);
        idle(4);
        rd_chk("R5 stalled status", OFS_STATUS, 16'h001E);
        check("R5 stall holds request low", {15'd0, xfer_req}, 16'h0000);

        // drain in order; pops release the stalled words
        data_chk("R4 first word", d);
        check("R6 first word trimmed", d, (16'hAB10 ^ ENG_XOR) & 16'h00FF);
        for (int k = 1; k < 10; k++) data_chk("R4 ordered read", d);
        idle(2);
        data_chk("R4 empty read returns zero", d);
        rd_chk("R4 empty read left state", OFS_STATUS, 16'h0003);

        // incoming threshold
        for (int k = 0; k < 3; k++) bus_write(OFS_DATA, 16'h0030 + 16'(k));
        idle(2);
        rd_chk("R7 rx three entries", OFS_RAW, 16'h0008);
        bus_write(OFS_DATA, 16'h0033);
        idle(2);
        rd_chk("R7 rx four entries", OFS_RAW, 16'h000C);
        for (int k = 0; k < 4; k++) data_chk("R4 threshold drain", d);

        // frame sizes
        eng_on = 1'b0;
        bus_write(OFS_FRAME, 16'h0003);
        bus_write(OFS_DATA, 16'hABCD);
        eng_on = 1'b1;
        idle(3);
        data_chk("R6 four bit frame", d);
        check("R6 four bit value", d, 16'h0007);
        eng_on = 1'b0;
        bus_write(OFS_FRAME, 16'h000F);
        bus_write(OFS_DATA, 16'hABCD);
        eng_on = 1'b1;
        idle(3);
        data_chk("R6 sixteen bit frame", d);
        check("R6 sixteen bit value", d, 16'hF197);
        rd_chk("R2 idle status", OFS_STATUS, 16'h0003);

        idle(2);
        summary();
    end

endmodule